// File: doc/BRIEF.md
# I2C Target Controller with Register Port

This block is a 7-bit-addressed I2C target that sits behind a small memory-mapped register port. It watches the bus lines through a synchronizer, detects START and STOP, compares the address byte against a programmable own address, and then moves data one byte at a time. Software supplies each byte to transmit and collects each received byte through a single data register.

While a byte is waiting for software, the block holds SCL low to stretch the clock, so the bus master cannot run ahead of software. A single register offset has two meanings. A write to it sets the enable bit. A read from it returns three flags: a receive request, a transmit request, and a marker for the first data byte after the address.

Software first programs the own address and sets the enable bit. It then polls the flags: it reads the data register when a byte has arrived and writes the data register when a byte is requested.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset the enable bit is 0, the status word reads 0, the data register reads 0 and the own-address register (offset 0x0, bits 6:0) reads the parameter default 0x42.
- R2: At offset 0x4 a write changes only the enable bit from wdata bit 0, and no other state. A read of 0x4 returns receive request in bit 0, transmit request in bit 1 and first-byte flag in bit 2, with bits 31:3 zero.
- R3: With the block enabled, it drives SDA low in the ninth clock only for an address byte whose upper seven bits equal the own address. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R4: While the enable bit is 0 the block never drives SDA or SCL low and acknowledges nothing.
- R5: In a write transfer (address bit 0 = 0), every data byte is acknowledged and sets the receive request. A read of offset 0x8 returns the byte and clears both the receive request and the first-byte flag.
- R6: The first-byte flag is set together with the receive request only for the first data byte after a matched address. It is 0 for later bytes and is never set in read transfers.
- R7: In a read transfer (address bit 0 = 1), the transmit request sets after the address acknowledge. A write to offset 0x8 (bits 7:0) clears the request, and that byte is shifted out MSB first.
- R8: An acknowledge from the master after a transmitted byte raises a new transmit request. A NACK ends the transfer with no further request.
- R9: While a receive or transmit request is pending, the block holds SCL low after the acknowledge phase. It releases SCL once software services the request.
- R10: A START or STOP in the middle of a byte aborts it. Only a START begins address detection, so after a STOP, clocked bits are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe, one cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 = pull SCL low |
| sda_oe_o | output | 1 | 1 = pull SDA low |

## Verification
The hardest case to reach is clock stretching. The block must pull SCL low while software is slow, and the master has to wait on the real line level. The bench models both bus lines as wired-AND of the master and the block's pull-downs. It runs the bus master and the software poller as concurrent threads, and the poller deliberately delays service so the held-low SCL can be observed. A repeated START placed after three address bits, and bits clocked after a STOP with no new START, cover the abort path.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK,
    ST_TX_REQ, ST_TX_WAIT, ST_TX, ST_TX_ACK
  } tgt_state_e;

  localparam int unsigned OFS_OWN  = 0;
  localparam int unsigned OFS_CTRL = 4;
  localparam int unsigned OFS_DATA = 8;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NL = 2; // 0: scl, 1: sda
  logic [NL-1:0] line_in, s1_q, s2_q, s3_q;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NL; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b1;
        s2_q[g] <= 1'b1;
        s3_q[g] <= 1'b1;
      end else begin
        s1_q[g] <= line_in[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end
  end

  assign sda_o      = s2_q[1];
  assign scl_rise_o = s2_q[0] & ~s3_q[0];
  assign scl_fall_o = ~s2_q[0] & s3_q[0];
  // SDA moving while SCL stays high
  assign start_o    = s2_q[0] & s3_q[0] & ~s2_q[1] & s3_q[1];
  assign stop_o     = s2_q[0] & s3_q[0] & s2_q[1] & ~s3_q[1];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          enable_i,
  input  logic [DW-2:0] own_addr_i,
  input  logic          rx_pend_i,
  input  logic          tx_pend_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          rx_done_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_first_o,
  output logic          tx_req_o,
  output logic          sda_oe_o,
  output logic          scl_oe_o
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  tgt_state_e    state_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          is_read_q, first_q, acked_q, sda_oe_q, rx_done_q, rx_first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      is_read_q  <= 1'b0;
      first_q    <= 1'b0;
      acked_q    <= 1'b0;
      sda_oe_q   <= 1'b0;
      rx_done_q  <= 1'b0;
      rx_first_q <= 1'b0;
    end else begin
      rx_done_q <= 1'b0;
      if (!enable_i || stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              if (sh_q[DW-1:1] == own_addr_i) begin
                sda_oe_q  <= 1'b1;
                is_read_q <= sh_q[0];
                state_q   <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            sda_oe_q <= 1'b0;
            cnt_q    <= '0;
            first_q  <= ~is_read_q;
            state_q  <= is_read_q ? ST_TX_REQ : ST_RX;
          end
          ST_RX: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              sda_oe_q   <= 1'b1;
              rx_done_q  <= 1'b1;
              rx_first_q <= first_q;
              first_q    <= 1'b0;
              state_q    <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: if (scl_fall_i) begin
            sda_oe_q <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_RX;
          end
          ST_TX_REQ: state_q <= ST_TX_WAIT;
          ST_TX_WAIT: if (!tx_pend_i) begin
            sh_q     <= tx_byte_i;
            sda_oe_q <= ~tx_byte_i[DW-1];
            cnt_q    <= '0;
            state_q  <= ST_TX;
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == CNT_LAST) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_TX_ACK;
            end else begin
              sda_oe_q <= ~sh_q[DW-2];
              sh_q     <= {sh_q[DW-2:0], 1'b0};
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) acked_q <= ~sda_i;
            else if (scl_fall_i) state_q <= acked_q ? ST_TX_REQ : ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_done_o  = rx_done_q;
  assign rx_byte_o  = sh_q;
  assign rx_first_o = rx_first_q;
  assign tx_req_o   = (state_q == ST_TX_REQ);
  assign sda_oe_o   = sda_oe_q;
  // stretch at the start of a byte until software catches up
  assign scl_oe_o   = (state_q == ST_RX && cnt_q == '0 && rx_pend_i)
                    || state_q == ST_TX_REQ || state_q == ST_TX_WAIT;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned RAW      = 4,
  parameter int unsigned RDW      = 32,
  parameter int unsigned DW       = 8,
  parameter logic [DW-2:0] DEF_ADDR = 7'h42
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [RAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [RDW-1:0] rdata_o,
  input  logic           rx_done_i,
  input  logic [DW-1:0]  rx_byte_i,
  input  logic           rx_first_i,
  input  logic           tx_req_i,
  output logic           enable_o,
  output logic [DW-2:0]  own_addr_o,
  output logic           rx_pend_o,
  output logic           tx_pend_o,
  output logic           first_o,
  output logic [DW-1:0]  tx_byte_o
);
  localparam int unsigned AW = DW - 1;
  localparam logic [RAW-1:0] A_OWN  = RAW'(OFS_OWN);
  localparam logic [RAW-1:0] A_CTRL = RAW'(OFS_CTRL);
  localparam logic [RAW-1:0] A_DATA = RAW'(OFS_DATA);

  logic [AW-1:0] own_q;
  logic [DW-1:0] rx_q, tx_q;
  logic          en_q, rxp_q, txp_q, first_q;
  logic          wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= DEF_ADDR;
      en_q    <= 1'b0;
      rx_q    <= '0;
      tx_q    <= '0;
      rxp_q   <= 1'b0;
      txp_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (wr && addr_i == A_OWN)  own_q <= wdata_i[AW-1:0];
      if (wr && addr_i == A_CTRL) en_q  <= wdata_i[0];
      if (wr && addr_i == A_DATA) begin
        tx_q  <= wdata_i;
        txp_q <= 1'b0;
      end
      if (tx_req_i) txp_q <= 1'b1;
      if (rd && addr_i == A_DATA) begin
        rxp_q   <= 1'b0;
        first_q <= 1'b0;
      end
      if (rx_done_i) begin
        rx_q    <= rx_byte_i;
        rxp_q   <= 1'b1;
        first_q <= rx_first_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_OWN:  rdata_o = {{(RDW-AW){1'b0}}, own_q};
      A_CTRL: rdata_o = {{(RDW-3){1'b0}}, first_q, txp_q, rxp_q};
      A_DATA: rdata_o = {{(RDW-DW){1'b0}}, rx_q};
      default: rdata_o = '0;
    endcase
  end

  assign enable_o   = en_q;
  assign own_addr_o = own_q;
  assign rx_pend_o  = rxp_q;
  assign tx_pend_o  = txp_q;
  assign first_o    = first_q;
  assign tx_byte_o  = tx_q;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl #(
  parameter int unsigned RAW      = 4,
  parameter int unsigned RDW      = 32,
  parameter int unsigned DW       = 8,
  parameter logic [DW-2:0] DEF_ADDR = 7'h42
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_req_i,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [RDW-1:0] reg_wdata_i,
  output logic [RDW-1:0] reg_rdata_o,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           scl_oe_o,
  output logic           sda_oe_o
);
  logic          sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic          enable, rx_pend, tx_pend, first_rx, rx_done, rx_first, tx_req;
  logic [DW-2:0] own_addr;
  logic [DW-1:0] rx_byte, tx_byte;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata_i[RDW-1:DW];

  i2c_tgt_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_tgt_engine #(.DW(DW)) u_engine (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c),
    .enable_i(enable), .own_addr_i(own_addr),
    .rx_pend_i(rx_pend), .tx_pend_i(tx_pend), .tx_byte_i(tx_byte),
    .rx_done_o(rx_done), .rx_byte_o(rx_byte), .rx_first_o(rx_first),
    .tx_req_o(tx_req), .sda_oe_o, .scl_oe_o
  );

  i2c_tgt_regs #(.RAW(RAW), .RDW(RDW), .DW(DW), .DEF_ADDR(DEF_ADDR)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i[DW-1:0]), .rdata_o(reg_rdata_o),
    .rx_done_i(rx_done), .rx_byte_i(rx_byte), .rx_first_i(rx_first),
    .tx_req_i(tx_req),
    .enable_o(enable), .own_addr_o(own_addr),
    .rx_pend_o(rx_pend), .tx_pend_o(tx_pend), .first_o(first_rx),
    .tx_byte_o(tx_byte)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned RAW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_req_i,
  input logic           reg_we_i,
  input logic [RAW-1:0] reg_addr_i,
  input logic           scl_oe_o,
  input logic           sda_oe_o,
  input logic           enable,
  input logic           rx_pend,
  input logic           tx_pend,
  input logic           first_rx,
  input logic           rx_done,
  input logic           tx_req
);
  localparam logic [RAW-1:0] A_DATA = RAW'(OFS_DATA);

  a_r4_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable && $past(!enable)) |-> (!sda_oe_o && !scl_oe_o));

  a_r5_read_clears_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == A_DATA && !rx_done) |=> (!rx_pend && !first_rx));

  a_r5_ack_with_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |-> sda_oe_o);

  a_r6_first_needs_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_rx |-> rx_pend);

  a_r6_no_first_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pend |-> !first_rx);

  a_r7_write_clears_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && reg_addr_i == A_DATA && !tx_req) |=> !tx_pend);

  a_r9_stretch_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> (rx_pend || tx_pend || tx_req || $past(tx_pend)));
endmodule

bind i2c_tgt_ctrl i2c_tgt_chk #(.RAW(RAW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .enable(enable), .rx_pend(rx_pend), .tx_pend(tx_pend), .first_rx(first_rx),
  .rx_done(rx_done), .tx_req(tx_req)
);

// File: tb/i2c_tgt_ctrl_tb_top.sv
module i2c_tgt_ctrl_tb_top;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4ns clk = ~clk;

  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        scl_oe, sda_oe, scl_line, sda_line;
  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;
  logic       model_en = 1'b0;
  logic [2:0] en_hist = '0;
  logic [6:0] own = 7'h42;

  i2c_tgt_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // R4 model: with enable off for several clocks, no line may be pulled
  always @(negedge clk) begin
    if (rst_n) begin
      en_hist <= {en_hist[1:0], model_en};
      if (en_hist == 3'b000 && !model_en) begin
        mon_checks++;
        if (scl_oe || sda_oe) begin
          mon_errors++;
          $display("FAIL R4 line pulled while disabled act=%b%b exp=00", scl_oe, sda_oe);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (a == 4'h4) model_en = d[0];
    #1ns req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1ns d = rdata;
    @(posedge clk);
    #1ns req = 1'b0;
  endtask

  task automatic poll_bit(input int b, output logic ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int k = 0; k < 4000 && !ok; k++) begin
      reg_read(4'h4, s);
      if (s[b]) ok = 1'b1;
    end
  endtask

  task automatic waitq();
    repeat (Q) @(posedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b;
    waitq();
    m_scl = 1'b1;
    @(posedge clk);
    while (!scl_line) @(posedge clk);
    waitq();
    r = sda_line;
    m_scl = 1'b0;
    waitq();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq();
    m_scl = 1'b1; waitq();
    m_sda = 1'b0; waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq();
    m_scl = 1'b1;
    @(posedge clk);
    while (!scl_line) @(posedge clk);
    waitq();
    m_sda = 1'b1; waitq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
    clk_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(~ack, r);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'h3C ^ 8'(i * 8'h5B);
  endfunction

  task automatic write_xfer(input int n, input logic partial);
    fork
      begin
        logic a, r;
        bus_start();
        if (partial) begin
          for (int i = 7; i > 4; i--) clk_bit(own[i-1], r);
          bus_start();
        end
        send_byte({own, 1'b0}, a);
        chk(partial ? "R10 address after repeated START" : "R3 own address acked", a, 1);
        for (int i = 0; i < n; i++) begin
          send_byte(pat(i), a);
          chk("R5 data byte acked", a, 1);
        end
        bus_stop();
      end
      begin
        logic ok;
        logic [31:0] s, d;
        for (int i = 0; i < n; i++) begin
          poll_bit(0, ok);
          chk("R5 rx request raised", ok, 1);
          reg_read(4'h4, s);
          chk("R6 first-byte flag", s[2], (i == 0));
          if (i == 0) begin
            repeat (200) @(posedge clk);
            chk("R9 SCL held during rx request", scl_line, 0);
          end
          reg_read(4'h8, d);
          chk("R5 received byte", d, pat(i));
          reg_read(4'h4, s);
          chk("R5 rx request and flag cleared", s[2:0], 0);
        end
      end
    join
  endtask

  initial begin
    logic [31:0] d;
    logic a, r;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    reg_read(4'h0, d); chk("R1 own address reset", d, 32'h42);
    reg_read(4'h4, d); chk("R1 status reset", d, 0);
    reg_read(4'h8, d); chk("R1 data reset", d, 0);

    reg_write(4'h4, 32'hFFFF_FFFE);
    reg_read(4'h4, d); chk("R2 ctrl write leaves status", d, 0);
    reg_read(4'h0, d); chk("R2 ctrl write leaves own address", d, 32'h42);

    bus_start();
    send_byte({own, 1'b0}, a);
    chk("R4 no ack while disabled", a, 0);
    bus_stop();
    reg_read(4'h4, d); chk("R4 no status while disabled", d, 0);

    reg_write(4'h4, 32'h1);

    bus_start();
    send_byte({7'h13, 1'b0}, a);
    chk("R3 foreign address not acked", a, 0);
    send_byte(8'h99, a);
    chk("R3 data after foreign address ignored", a, 0);
    bus_stop();
    reg_read(4'h4, d); chk("R3 no status after foreign address", d, 0);

    reg_write(4'h0, 32'hFFFF_FFD5);
    reg_read(4'h0, d); chk("R3 own address reprogrammed", d, 32'h55);
    own = 7'h55;

    write_xfer(3, 1'b0);

    fork
      begin
        logic [7:0] v0, v1;
        bus_start();
        send_byte({own, 1'b1}, a);
        chk("R7 read address acked", a, 1);
        recv_byte(1'b1, v0);
        recv_byte(1'b0, v1);
        bus_stop();
        chk("R7 first byte MSB first", v0, 8'hA6);
        chk("R8 byte after master ack", v1, 8'h59);
      end
      begin
        logic ok;
        logic [31:0] s;
        for (int i = 0; i < 2; i++) begin
          poll_bit(1, ok);
          chk(i == 0 ? "R7 tx request raised" : "R8 tx request after ack", ok, 1);
          reg_read(4'h4, s);
          chk("R6 no first-byte flag in read", s[2], 0);
          if (i == 0) begin
            repeat (200) @(posedge clk);
            chk("R9 SCL held during tx request", scl_line, 0);
          end
          reg_write(4'h8, (i == 0) ? 32'h0000_01A6 : 32'h0000_0259);
          reg_read(4'h4, s);
          chk("R7 tx request cleared by write", s[1], 0);
        end
      end
    join
    repeat (300) @(posedge clk);
    reg_read(4'h4, d); chk("R8 no request after NACK", d, 0);

    write_xfer(1, 1'b1);

    bus_start();
    for (int i = 7; i > 3; i--) clk_bit(own[i-1], r);
    bus_stop();
    send_byte({own, 1'b0}, a);
    chk("R10 bits after STOP not acked", a, 0);
    bus_stop();
    reg_read(4'h4, d); chk("R10 no status after STOP", d, 0);

    reg_write(4'h4, 32'h0);
    repeat (20) @(posedge clk);

    checks += mon_checks;
    errors += mon_errors;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule